// File: doc/BRIEF.md
# Reconfigurable Multiply-Accumulate Tree Array

This block is the arithmetic core of a convolution engine. It holds one pool of 256 signed 8-bit multipliers. A mode input regroups their adder trees between two shapes. In narrow mode there are sixty-four small trees of 4 products each. This suits layers with few input channels, such as the image input layer, where many kernels are worked on in parallel. In wide mode there are four large trees of 64 products each. This suits deep intermediate layers with many channels, where a long channel dot product is reduced at once.

Every accepted beat carries 256 activations and 256 weights. Each tree output is added into its own 32-bit accumulator, so a result is built up over as many beats as the layer needs. A beat flagged as last closes the sum. It presents all result slots with a one-cycle valid pulse and restarts the accumulators at zero. The narrow trees are also the first pipeline stage of the wide trees. Because of this, a narrow beat reaches its accumulator after one register stage and a wide beat after three.

Top module: `mac_tree_array`

## Requirements
- R1: In narrow mode (`mode_wide`=0), result slot k is the signed sum over the beats of one accumulation of act[i]*wgt[i] for lanes i = 4k..4k+3. Lane i sits at bits [8i+7:8i] of each input bus and slot k at bits [32k+31:32k] of `res_flat`, as 8-bit two's complement inputs and 32-bit two's complement wrapping results.
- R2: In wide mode (`mode_wide`=1), result slot k (k = 0..3) is the same signed sum taken over lanes 64k..64k+63.
- R3: A narrow beat sampled at rising edge n reaches its accumulator at edge n+1, and a wide beat at edge n+3. When that beat is a last beat, `out_valid` is high for exactly the cycle after that edge. `res_flat` holds its value until the next result.
- R4: A wide-mode result reads zero in slots 4..63.
- R5: After a last beat, the next accumulation starts from zero in every slot.
- R6: The mode is taken from `mode_wide` only on a beat that arrives while the array is idle, meaning no accumulation is open and no beat is in flight. Otherwise the beat uses the mode already in force, and a different request is ignored.
- R7: `acc_clear` zeroes every accumulator, drops all beats in flight and the beat offered in the same cycle, suppresses `out_valid`, and makes the array idle, so that the next beat may change mode.
- R8: After reset, `out_valid` is 0, every result slot is 0 and the mode is narrow.
- R9: Cycles with `in_valid` low change no accumulator and no output, whatever is on the data and control inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_wide | input | 1 | Requested grouping: 1 = four 64-input trees, 0 = sixty-four 4-input trees |
| in_valid | input | 1 | Beat present on the data inputs |
| in_last | input | 1 | This beat closes the current accumulation |
| acc_clear | input | 1 | Abort: zero accumulators and flush the pipeline |
| act_flat | input | 2048 | 256 signed 8-bit activations, lane i at [8i+7:8i] |
| wgt_flat | input | 2048 | 256 signed 8-bit weights, lane i at [8i+7:8i] |
| out_valid | output | 1 | One-cycle pulse when a result is presented |
| res_flat | output | 2048 | 64 signed 32-bit results, slot k at [32k+31:32k] |

## Verification
The bench aims at the latency difference between the two groupings. A design that used one latency for both would accumulate a wide beat into the wrong cycle or collide with a following narrow beat, and the pulse would come early or late. It also requests a mode change in the middle of an open sum, and again while a wide last beat is still draining. A design that obeyed such a request would regroup lanes partway through and mix partial sums of different shapes. It fires a clear with a beat on the same cycle and with beats in flight; a leaky flush would leave stale products in the next result. Extreme operands (-128 times -128 over all lanes across several beats) show whether sign extension through the tree levels and the 32-bit accumulators is handled correctly.

// File: rtl/mac_tree_array.sv
module mac_tree_array #(
  parameter int LANES = 256,
  parameter int DW    = 8,
  parameter int ACCW  = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mode_wide,
  input  logic                   in_valid,
  input  logic                   in_last,
  input  logic                   acc_clear,
  input  logic [LANES*DW-1:0]    act_flat,
  input  logic [LANES*DW-1:0]    wgt_flat,
  output logic                   out_valid,
  output logic [(LANES/4)*ACCW-1:0] res_flat
);
  localparam int NG  = LANES / 4;
  localparam int G2  = LANES / 16;
  localparam int WG  = LANES / 64;
  localparam int PW  = 2 * DW;
  localparam int S1W = PW + 2;
  localparam int S2W = PW + 4;
  localparam int S3W = PW + 6;

  logic signed [PW-1:0]   prod  [LANES];
  logic signed [S1W-1:0]  s1_d  [NG];
  logic signed [S1W-1:0]  s1_q  [NG];
  logic signed [S2W-1:0]  s2_q  [G2];
  logic signed [S3W-1:0]  s3_q  [WG];
  logic signed [ACCW-1:0] contrib [NG];
  logic signed [ACCW-1:0] acc_q [NG];
  logic signed [ACCW-1:0] res_q [NG];

  logic v1, l1, w1, v2, l2, v3, l3;
  logic mode_q, open_q, res_wide;

  wire idle     = !open_q && !v1 && !v2 && !v3;
  wire mode_now = idle ? mode_wide : mode_q;
  wire apply    = v3 || (v1 && !w1);
  wire app_last = v3 ? l3 : l1;

  always_comb begin
    for (int i = 0; i < LANES; i++)
      prod[i] = $signed(act_flat[i*DW +: DW]) * $signed(wgt_flat[i*DW +: DW]);
    for (int g = 0; g < NG; g++)
      s1_d[g] = S1W'(prod[4*g]) + S1W'(prod[4*g+1]) + S1W'(prod[4*g+2]) + S1W'(prod[4*g+3]);
  end

  always_comb begin
    for (int g = 0; g < NG; g++) begin
      if (v3) contrib[g] = (g < WG) ? ACCW'(s3_q[g]) : '0;
      else    contrib[g] = ACCW'(s1_q[g]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {v1, l1, w1, v2, l2, v3, l3} <= '0;
      {mode_q, open_q, res_wide, out_valid} <= '0;
      for (int g = 0; g < NG; g++) begin
        s1_q[g] <= '0; acc_q[g] <= '0; res_q[g] <= '0;
      end
      for (int h = 0; h < G2; h++) s2_q[h] <= '0;
      for (int k = 0; k < WG; k++) s3_q[k] <= '0;
    end else if (acc_clear) begin
      {v1, v2, v3, open_q, out_valid} <= '0;
      for (int g = 0; g < NG; g++) acc_q[g] <= '0;
    end else begin
      v1 <= in_valid;
      l1 <= in_last;
      w1 <= mode_now;
      for (int g = 0; g < NG; g++) s1_q[g] <= s1_d[g];
      if (in_valid) begin
        mode_q <= mode_now;
        open_q <= !in_last;
      end
      v2 <= v1 && w1;
      l2 <= l1;
      for (int h = 0; h < G2; h++)
        s2_q[h] <= S2W'(s1_q[4*h]) + S2W'(s1_q[4*h+1]) + S2W'(s1_q[4*h+2]) + S2W'(s1_q[4*h+3]);
      v3 <= v2;
      l3 <= l2;
      for (int k = 0; k < WG; k++)
        s3_q[k] <= S3W'(s2_q[4*k]) + S3W'(s2_q[4*k+1]) + S3W'(s2_q[4*k+2]) + S3W'(s2_q[4*k+3]);
      out_valid <= apply && app_last;
      if (apply && app_last) res_wide <= v3;
      if (apply) begin
        for (int g = 0; g < NG; g++) begin
          if (app_last) begin
            res_q[g] <= acc_q[g] + contrib[g];
            acc_q[g] <= '0;
          end else begin
            acc_q[g] <= acc_q[g] + contrib[g];
          end
        end
      end
    end
  end

  always_comb
    for (int g = 0; g < NG; g++) res_flat[g*ACCW +: ACCW] = res_q[g];

  assert_no_collision_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(v3 && v1 && !w1));
  assert_wide_stage2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && w1 && !acc_clear) |=> v2);
  assert_wide_stage3_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (v2 && !acc_clear) |=> v3);
  assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !acc_clear) |=> $stable(mode_q));
  assert_clear_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clear |=> (!out_valid && !v1 && !v2 && !v3 && !open_q));
  assert_unused_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && res_wide) |-> (res_flat[NG*ACCW-1:WG*ACCW] == '0));
endmodule

// File: tb/mac_tree_array_test.sv
module mac_tree_array_test;
  localparam int LANES = 256;
  localparam int NG = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_wide = 1'b0, in_valid = 1'b0, in_last = 1'b0, acc_clear = 1'b0;
  logic [LANES*8-1:0] act_flat = '0, wgt_flat = '0;
  logic out_valid;
  logic [NG*32-1:0] res_flat;

  mac_tree_array uut (
    .clk(clk), .rst_n(rst_n), .mode_wide(mode_wide), .in_valid(in_valid),
    .in_last(in_last), .acc_clear(acc_clear), .act_flat(act_flat),
    .wgt_flat(wgt_flat), .out_valid(out_valid), .res_flat(res_flat));

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  string cur_req = "R8";

  int m_acc [NG];
  int m_res [NG];
  bit m_ov = 0, m_mode = 0, m_open = 0;
  int due_q [$];
  bit last_q [$];
  logic [NG*32-1:0] sum_q [$];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < NG; g++) begin m_acc[g] = 0; m_res[g] = 0; end
      m_ov = 0; m_mode = 0; m_open = 0;
      due_q.delete(); last_q.delete(); sum_q.delete();
    end else if (acc_clear) begin
      for (int g = 0; g < NG; g++) m_acc[g] = 0;
      m_ov = 0; m_open = 0;
      due_q.delete(); last_q.delete(); sum_q.delete();
    end else begin
      bit idle;
      idle = !m_open && (due_q.size() == 0);
      m_ov = 0;
      if (due_q.size() > 0 && due_q[0] == cyc) begin
        logic [NG*32-1:0] s;
        bit l;
        s = sum_q.pop_front(); l = last_q.pop_front(); void'(due_q.pop_front());
        for (int g = 0; g < NG; g++) m_acc[g] = m_acc[g] + int'(s[32*g +: 32]);
        if (l) begin
          for (int g = 0; g < NG; g++) begin m_res[g] = m_acc[g]; m_acc[g] = 0; end
          m_ov = 1;
        end
      end
      if (in_valid) begin
        int sums [NG];
        logic [NG*32-1:0] pk;
        if (idle) m_mode = mode_wide;
        for (int g = 0; g < NG; g++) sums[g] = 0;
        for (int i = 0; i < LANES; i++) begin
          int a, b, t;
          a = int'($signed(act_flat[8*i +: 8]));
          b = int'($signed(wgt_flat[8*i +: 8]));
          t = m_mode ? i / 64 : i / 4;
          sums[t] = sums[t] + a * b;
        end
        for (int g = 0; g < NG; g++) pk[32*g +: 32] = sums[g];
        sum_q.push_back(pk); last_q.push_back(in_last);
        due_q.push_back(cyc + (m_mode ? 3 : 1));
        m_open = !in_last;
      end
    end
    cyc++;
  end

  always @(negedge clk) begin
    if (cyc > 0 && !done) begin
      checks++;
      if (out_valid !== m_ov) begin
        fails++;
        $display("FAIL %s out_valid actual=%0b expected=%0b cycle=%0d", cur_req, out_valid, m_ov, cyc);
      end
      for (int g = 0; g < NG; g++) begin
        checks++;
        if ($signed(res_flat[32*g +: 32]) !== m_res[g]) begin
          fails++;
          $display("FAIL %s slot %0d actual=%0d expected=%0d cycle=%0d", cur_req, g,
                   $signed(res_flat[32*g +: 32]), m_res[g], cyc);
        end
      end
    end
  end

  task automatic fill(input int kind);
    for (int i = 0; i < LANES; i++) begin
      case (kind)
        1: begin act_flat[8*i +: 8] = 8'h80; wgt_flat[8*i +: 8] = 8'h80; end
        2: begin act_flat[8*i +: 8] = 8'h7f; wgt_flat[8*i +: 8] = 8'h80; end
        default: begin act_flat[8*i +: 8] = 8'($urandom); wgt_flat[8*i +: 8] = 8'($urandom); end
      endcase
    end
  endtask

  task automatic beat(input bit wide, input bit last, input int kind);
    @(negedge clk);
    fill(kind);
    mode_wide = wide; in_valid = 1; in_last = last; acc_clear = 0;
  endtask

  task automatic gap(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      fill(0);
      in_valid = 0; in_last = 1'($urandom); mode_wide = 1'($urandom); acc_clear = 0;
    end
  endtask

  task automatic clear_with_beat;
    @(negedge clk);
    fill(0);
    in_valid = 1; in_last = 1; acc_clear = 1; mode_wide = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    gap(2);
    cur_req = "R1";
    beat(0, 1, 0); gap(3);
    beat(0, 0, 0); beat(0, 0, 0); beat(0, 1, 0); gap(3);
    cur_req = "R9";
    beat(0, 0, 0); gap(4); beat(0, 0, 2); gap(2); beat(0, 1, 0); gap(4);
    cur_req = "R2";
    beat(1, 1, 0); gap(5);
    beat(1, 0, 1); beat(1, 0, 1); beat(1, 1, 1); gap(5);
    cur_req = "R4";
    beat(1, 0, 0); beat(1, 1, 2); gap(5);
    cur_req = "R3";
    beat(0, 1, 0); beat(0, 1, 0); beat(0, 1, 0); gap(1);
    beat(1, 1, 0); beat(1, 1, 0); beat(1, 0, 0); beat(1, 1, 0); gap(5);
    cur_req = "R5";
    beat(0, 0, 1); beat(0, 1, 1); beat(0, 1, 0); gap(3);
    cur_req = "R6";
    beat(0, 0, 0); beat(1, 0, 0); beat(1, 1, 0); gap(3);
    beat(1, 1, 0); beat(0, 0, 0); beat(0, 1, 0); gap(6);
    beat(0, 1, 0); gap(3);
    cur_req = "R7";
    beat(0, 0, 0); beat(0, 0, 0); clear_with_beat();
    beat(1, 1, 0); gap(5);
    beat(1, 0, 0); beat(1, 0, 0); clear_with_beat();
    beat(0, 0, 0); beat(0, 1, 0); gap(4);
    cur_req = "R8";
    @(negedge clk); rst_n = 0; in_valid = 0; acc_clear = 0;
    gap(2);
    @(negedge clk); rst_n = 1;
    beat(0, 1, 0); gap(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule